// File: doc/BRIEF.md
# Greedy Graph-Coloring Column Encoder

This block gives every column of a decomposition chart a small code, or color. Columns that are compatible may share a code, and columns that are not compatible are pushed apart. The caller loads a column count with a start pulse. The caller then supplies the compatibility graph as one adjacency row per pass. Row k holds one bit per column, and bit j is set when column j is compatible with column k.

The block has one code register and one processing element per column. A column counter picks the reference column for each pass. The reference code is routed through a wide multiplexer to every element, and all elements update in the same cycle. When the last pass ends, the counter restarts and the block presents the final codes, one per cycle, with a valid strobe and the column index. A done flag then stays high until the next start.

The heuristic is greedy and finishes in a fixed number of steps. It spends one accepted row per active column, then one output beat per active column. It makes no attempt to find a minimal coloring.

Top module: `gcolor_encoder`

## Requirements
- R1: After reset, `busy`, `done`, `code_valid` and `row_ready` are all low.
- R2: A `start` pulse is accepted only while `busy` is low. A start while busy is ignored, and the run in progress finishes with its original column count and results.
- R3: Accepting a start clears every column code to 0, so no result carries over from an earlier run.
- R4: A pass is consumed only in a cycle where `row_ready` and `row_valid` are both high. Gaps in `row_valid` stall the passes without changing the result. Passes take rows for reference columns 0, 1, 2 and so on, in that order.
- R5: In a pass with reference column k, an active column i other than k keeps its code when `row_data[i]` is 1, or when its code differs from column k's code. Otherwise its code increments by one.
- R6: The reference column's own code never changes during its pass, whatever the value of its own bit in the row.
- R7: After the last pass, exactly N beats are presented, where N is the effective column count. On each beat `code_valid` is high, and `code_idx` runs 0, 1, ..., N-1 in consecutive cycles. Columns at index N or above do not change and are not presented.
- R8: With 8 columns, when row 0 marks only columns 1 and 6 (plus itself) as compatible and every later row is all ones, the codes read out are 0,0,1,1,1,1,0,1.
- R9: The cycle after the last beat, `done` rises and `busy` falls. `done` stays high until the next accepted start.
- R10: A `col_count` of 0 produces no passes and no beats and goes straight to done. A value above 16 is treated as 16.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Start pulse, taken only when not busy |
| col_count | input | 5 | Number of active columns, sampled at start |
| row_valid | input | 1 | Adjacency row present on `row_data` |
| row_data | input | 16 | Compatibility row of the current reference column |
| row_ready | output | 1 | High while the block is waiting for passes |
| code_valid | output | 1 | Readout beat strobe |
| code_idx | output | 4 | Column index of the current beat |
| code_out | output | 4 | Final code of column `code_idx` |
| busy | output | 1 | A run is in progress |
| done | output | 1 | Results have been read out; held until next start |

## Verification
The hardest case to reach from the ports is a column that gets bumped in several passes, because only then do high code values and chained collisions appear. Sparse random rows, mostly zeros, with the diagonal bit randomized, push many columns through repeated increments. Random idle gaps between rows check that stalls change nothing. A start pulse fired in the middle of a run checks that it is ignored. Directed runs cover the worked 8-column example, a zero count, an oversized count and a fully incompatible graph.

// File: rtl/gcolor_pkg.sv
// Package: shared parameters and types for the greedy column encoder.
// Assumes at most 16 columns with 4-bit codes by default.
package gcolor_pkg;
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_PASS = 2'd1,
        ST_OUT  = 2'd2,
        ST_DONE = 2'd3
    } gce_state_e;
endpackage

// File: rtl/gcolor_elem.sv
// Per-column processing element. Holds one column code and applies the
// keep-or-advance rule against the reference column's code.
// Assumes clr and en are never asserted together by the controller.
module gcolor_elem #(
    parameter int CW = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr,
    input  logic          en,
    input  logic          active,
    input  logic          is_ref,
    input  logic          compat,
    input  logic [CW-1:0] ref_code,
    output logic [CW-1:0] code
);
    logic [CW-1:0] code_q;
    logic          differ;
    logic          keep;

    // Compare own code with the reference and form the keep select.
    always_comb begin
        differ = (code_q != ref_code);
        keep   = compat | differ | is_ref | ~active;
    end

    // Code register: clear on start, advance on an unresolved collision.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            code_q <= '0;
        end else if (clr) begin
            code_q <= '0;
        end else if (en && !keep) begin
            code_q <= code_q + CW'(1);
        end
    end

    assign code = code_q;
endmodule

// File: rtl/gcolor_mux.sv
// Column code selector: picks one code out of a flat vector of all codes.
// Used both for the reference code and for the readout path.
module gcolor_mux #(
    parameter int NCOL = 16,
    parameter int CW   = 4,
    localparam int IW  = $clog2(NCOL)
) (
    input  logic [NCOL*CW-1:0] codes_flat,
    input  logic [IW-1:0]      sel,
    output logic [CW-1:0]      code_sel
);
    // Indexed slice of the selected column.
    always_comb begin
        code_sel = codes_flat[sel*CW +: CW];
    end
endmodule

// File: rtl/gcolor_ctrl.sv
// Sequencer: accepts start, counts passes over the reference columns,
// then counts readout beats. Holds the effective column count.
// Assumes col_count is sampled only in the cycle start is accepted.
module gcolor_ctrl
    import gcolor_pkg::*;
#(
    parameter int NCOL = 16,
    localparam int IW  = $clog2(NCOL),
    localparam int NW  = $clog2(NCOL + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic [NW-1:0] col_count,
    input  logic          row_valid,
    output logic [IW-1:0] ctr,
    output logic [NW-1:0] cnt_q,
    output logic          clr,
    output logic          upd_en,
    output logic          row_ready,
    output logic          code_valid,
    output logic          busy,
    output logic          done
);
    gce_state_e    state_q;
    logic [IW-1:0] ctr_q;
    logic [NW-1:0] cnt_r;
    logic [NW-1:0] clamped;
    logic          idle_like;
    logic          last;

    // Clamp the requested count and detect the last column index.
    always_comb begin
        clamped   = (col_count > NW'(NCOL)) ? NW'(NCOL) : col_count;
        idle_like = (state_q == ST_IDLE) || (state_q == ST_DONE);
        last      = (NW'(ctr_q) == (cnt_r - NW'(1)));
    end

    // State, column counter and count register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            ctr_q   <= '0;
            cnt_r   <= '0;
        end else begin
            case (state_q)
                ST_IDLE, ST_DONE: begin
                    if (start) begin
                        cnt_r   <= clamped;
                        ctr_q   <= '0;
                        state_q <= (clamped == '0) ? ST_DONE : ST_PASS;
                    end
                end
                ST_PASS: begin
                    if (row_valid) begin
                        if (last) begin
                            ctr_q   <= '0;
                            state_q <= ST_OUT;
                        end else begin
                            ctr_q <= ctr_q + IW'(1);
                        end
                    end
                end
                ST_OUT: begin
                    if (last) begin
                        ctr_q   <= '0;
                        state_q <= ST_DONE;
                    end else begin
                        ctr_q <= ctr_q + IW'(1);
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    // Decoded controls toward the datapath and the ports.
    always_comb begin
        clr        = start && idle_like;
        row_ready  = (state_q == ST_PASS);
        upd_en     = row_ready && row_valid;
        code_valid = (state_q == ST_OUT);
        busy       = (state_q == ST_PASS) || (state_q == ST_OUT);
        done       = (state_q == ST_DONE);
    end

    assign ctr   = ctr_q;
    assign cnt_q = cnt_r;
endmodule

// File: rtl/gcolor_encoder.sv
// Top: greedy graph-coloring column encoder. One element per column,
// a shared code selector for reference and readout, and a sequencer.
// Assumes row k presented on the k-th accepted pass describes column k.
module gcolor_encoder #(
    parameter int NCOL = 16,
    parameter int CW   = 4,
    localparam int IW  = $clog2(NCOL),
    localparam int NW  = $clog2(NCOL + 1)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            start,
    input  logic [NW-1:0]   col_count,
    input  logic            row_valid,
    input  logic [NCOL-1:0] row_data,
    output logic            row_ready,
    output logic            code_valid,
    output logic [IW-1:0]   code_idx,
    output logic [CW-1:0]   code_out,
    output logic            busy,
    output logic            done
);
    logic [IW-1:0]      ctr;
    logic [NW-1:0]      cnt_q;
    logic               clr;
    logic               upd_en;
    logic [NCOL*CW-1:0] codes_flat;
    logic [CW-1:0]      sel_code;

    gcolor_ctrl #(.NCOL(NCOL)) u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .start      (start),
        .col_count  (col_count),
        .row_valid  (row_valid),
        .ctr        (ctr),
        .cnt_q      (cnt_q),
        .clr        (clr),
        .upd_en     (upd_en),
        .row_ready  (row_ready),
        .code_valid (code_valid),
        .busy       (busy),
        .done       (done)
    );

    gcolor_mux #(.NCOL(NCOL), .CW(CW)) u_mux (
        .codes_flat (codes_flat),
        .sel        (ctr),
        .code_sel   (sel_code)
    );

    for (genvar gi = 0; gi < NCOL; gi++) begin : g_elem
        logic act;
        logic isr;
        // Element is active below the count and is the reference when selected.
        always_comb begin
            act = (NW'(gi) < cnt_q);
            isr = (ctr == IW'(gi));
        end
        gcolor_elem #(.CW(CW)) u_elem (
            .clk      (clk),
            .rst_n    (rst_n),
            .clr      (clr),
            .en       (upd_en),
            .active   (act),
            .is_ref   (isr),
            .compat   (row_data[gi]),
            .ref_code (sel_code),
            .code     (codes_flat[gi*CW +: CW])
        );
    end

    assign code_idx = ctr;
    assign code_out = sel_code;
endmodule

// File: rtl/gcolor_encoder_chk.sv
// Checker for the column encoder, bound to the top module.
module gcolor_encoder_chk #(
    parameter int NCOL = 16,
    parameter int CW   = 4,
    localparam int IW  = $clog2(NCOL),
    localparam int NW  = $clog2(NCOL + 1)
) (
    input logic               clk,
    input logic               rst_n,
    input logic               start,
    input logic               row_ready,
    input logic               code_valid,
    input logic [IW-1:0]      code_idx,
    input logic               busy,
    input logic               done,
    input logic               upd_en,
    input logic               clr,
    input logic [IW-1:0]      ctr,
    input logic [NW-1:0]      cnt_q,
    input logic [CW-1:0]      sel_code,
    input logic [NCOL*CW-1:0] codes_flat
);
    logic          upd_d;
    logic [IW-1:0] ref_d;
    logic [CW-1:0] refc_d;

    // Capture the reference column and its code of each pass.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            upd_d  <= 1'b0;
            ref_d  <= '0;
            refc_d <= '0;
        end else begin
            upd_d  <= upd_en;
            ref_d  <= ctr;
            refc_d <= sel_code;
        end
    end

    assert_reset_idle_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (!busy && !done && !code_valid && !row_ready));

    assert_start_ignored_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && start) |=> (cnt_q == $past(cnt_q)));

    assert_clear_on_start_R3: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (codes_flat == '0));

    assert_no_pass_in_readout_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !(row_ready && code_valid));

    assert_ref_keeps_R6: assert property (@(posedge clk) disable iff (!rst_n)
        upd_d |-> (codes_flat[ref_d*CW +: CW] == refc_d));

    assert_beats_in_order_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (code_valid && $past(code_valid)) |-> (code_idx == $past(code_idx) + IW'(1)));

    assert_beat_below_count_R7: assert property (@(posedge clk) disable iff (!rst_n)
        code_valid |-> (NW'(code_idx) < cnt_q));

    assert_done_after_last_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (code_valid && (NW'(code_idx) == cnt_q - NW'(1))) |=> (done && !busy));

    assert_busy_done_excl_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !(busy && done));
endmodule

bind gcolor_encoder gcolor_encoder_chk #(.NCOL(NCOL), .CW(CW)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .start      (start),
    .row_ready  (row_ready),
    .code_valid (code_valid),
    .code_idx   (code_idx),
    .busy       (busy),
    .done       (done),
    .upd_en     (upd_en),
    .clr        (clr),
    .ctr        (ctr),
    .cnt_q      (cnt_q),
    .sel_code   (sel_code),
    .codes_flat (codes_flat)
);

// File: tb/gcolor_encoder_tb.sv
module gcolor_encoder_tb;
    localparam int CLK_PERIOD = 10;
    localparam int NCOL = 16;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [4:0]  col_count = '0;
    logic        row_valid = 1'b0;
    logic [15:0] row_data = '0;
    logic        row_ready, code_valid, busy, done;
    logic [3:0]  code_idx, code_out;

    int n_checks = 0;
    int n_fail   = 0;

    logic [15:0] rows  [NCOL];
    logic [3:0]  exp_c [NCOL];
    logic [3:0]  got_c [NCOL];
    int          got_n;
    bit          order_ok;

    always #(CLK_PERIOD/2) clk = ~clk;

    gcolor_encoder u_dut (
        .clk(clk), .rst_n(rst_n), .start(start), .col_count(col_count),
        .row_valid(row_valid), .row_data(row_data), .row_ready(row_ready),
        .code_valid(code_valid), .code_idx(code_idx), .code_out(code_out),
        .busy(busy), .done(done)
    );

    task automatic chk(input bit ok, input string req, input int act, input int expv);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
        end
    endtask

    function automatic int eff_count(input int c);
        return (c > NCOL) ? NCOL : c;
    endfunction

    // Expected codes from the update rule of the requirements.
    task automatic model(input int c);
        int n = eff_count(c);
        for (int i = 0; i < NCOL; i++) exp_c[i] = 4'd0;
        for (int k = 0; k < n; k++) begin
            logic [3:0] rc = exp_c[k];
            for (int i = 0; i < n; i++) begin
                if (i != k && !rows[k][i] && exp_c[i] == rc) exp_c[i] = exp_c[i] + 4'd1;
            end
        end
    endtask

    // One complete run: start, feed rows with random gaps, collect beats.
    task automatic run_case(input int c, input int gap_pct, input bit inject, input string req);
        int k = 0;
        int cyc = 0;
        int n = eff_count(c);
        model(c);
        @(negedge clk);
        col_count = 5'(c);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        got_n = 0;
        order_ok = 1'b1;
        while (!done && cyc < 2000) begin
            if (code_valid) begin
                if (int'(code_idx) != got_n) order_ok = 1'b0;
                if (got_n < NCOL) got_c[got_n] = code_out;
                got_n++;
            end
            if (row_ready && k < NCOL && int'($urandom % 100) >= gap_pct) begin
                row_valid = 1'b1;
                row_data  = rows[k];
                k++;
            end else begin
                row_valid = 1'b0;
                row_data  = 16'($urandom);
            end
            if (inject && cyc == 2) begin
                start = 1'b1;
                col_count = 5'd3;
            end else begin
                start = 1'b0;
            end
            @(negedge clk);
            cyc++;
        end
        row_valid = 1'b0;
        start = 1'b0;
        chk(got_n == n, "R7 beat count", got_n, n);
        chk(order_ok, "R7 beat order", order_ok, 1);
        for (int i = 0; i < n && i < got_n; i++)
            chk(got_c[i] == exp_c[i], req, got_c[i], exp_c[i]);
        chk(done && !busy, "R9 done level", {done, busy}, 2);
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog expired actual=1 expected=0");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        int seed_dummy;
        seed_dummy = $urandom(32'd24681);
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: idle after reset
        chk(!busy && !done && !code_valid && !row_ready, "R1 reset state",
            {busy, done, code_valid, row_ready}, 0);

        // R8: worked 8-column example
        for (int i = 0; i < NCOL; i++) rows[i] = 16'hFFFF;
        rows[0] = 16'h0043;
        run_case(8, 0, 1'b0, "R8 example codes");
        chk(exp_c[2] == 4'd1 && exp_c[6] == 4'd0, "R8 model sanity", exp_c[2], 1);

        // R9: done held until next start
        repeat (5) @(negedge clk);
        chk(done && !code_valid, "R9 done held", done, 1);

        // R5: fully incompatible graph, diagonal clear, gives distinct codes
        for (int i = 0; i < NCOL; i++) rows[i] = 16'h0000;
        run_case(16, 0, 1'b0, "R5 all incompatible");
        // R6: same graph with diagonal set must give the same codes
        for (int i = 0; i < NCOL; i++) rows[i] = 16'(1) << i;
        run_case(16, 30, 1'b0, "R6 diagonal ignored");

        // R3: all-compatible run after a nonzero result must read all zeros
        for (int i = 0; i < NCOL; i++) rows[i] = 16'hFFFF;
        run_case(12, 0, 1'b0, "R3 cleared codes");

        // R10: zero count and oversized count
        run_case(0, 0, 1'b0, "R10 zero count");
        for (int i = 0; i < NCOL; i++) rows[i] = 16'(1) << ((i + 1) % NCOL);
        run_case(25, 10, 1'b0, "R10 clamped count");

        // R2: start while busy is ignored
        for (int i = 0; i < NCOL; i++) rows[i] = 16'($urandom) & 16'($urandom);
        run_case(10, 20, 1'b1, "R2 start ignored");

        // R4 and R5: random sparse graphs with random stalls
        for (int t = 0; t < 40; t++) begin
            int c = 1 + int'($urandom % NCOL);
            for (int i = 0; i < NCOL; i++)
                rows[i] = 16'($urandom) & 16'($urandom) & 16'($urandom);
            run_case(c, int'($urandom % 60), 1'b0, "R4 R5 random graph");
        end

        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule